// File: doc/BRIEF.md
# Busy Source Monitor and Router

This block watches the flow-control byte produced by an upstream receiver and the single-cycle parity-error strobe that accompanies it. The byte carries two nibbles; in each nibble the top bit is an odd-parity bit and the three lower bits are busy sources. Six busy sources therefore exist: bits 0, 1, 2, 4, 5 and 6. Whenever any of them is high, the block raises a combined busy signal.

A routing mask, written through a small register port, decides which of four destination lanes carry that busy. Lane 0 feeds the trigger-object path and lanes 1 to 3 feed three bulk readout paths. Each lane is the combined busy ANDed with its mask bit, and each lane is registered.

For diagnosis, the block also keeps a saturating count of parity-error strobes and one sticky flag per busy source. Software reads these through the same port. It clears them only by writing a dedicated clear register, which returns zero on read.

Top module: `busy_monitor`

## Requirements
- R1: `busy_now` is high exactly when any of message bits 0, 1, 2, 4, 5 or 6 is 1. Bits 3 and 7 (the parity bits) have no effect on it.
- R2: Each busy source has a sticky flag. Flag bits 2:0 follow message bits 2:0, and flag bits 5:3 follow message bits 6:4. A flag is set at the clock edge after its source bit is seen high.
- R3: A set flag stays set until a flag clear is issued, even after its source bit returns to 0.
- R4: The 16-bit parity-error counter increments by one for each cycle in which `perr_pulse` is high. It holds its value in every other cycle.
- R5: The counter saturates at 16'hFFFF and does not wrap.
- R6: A write to offset 2 clears state. Bit 0 of the written data clears the counter and bit 1 clears all flags, both at that clock edge. A clear wins over a parity strobe or a source bit in the same cycle.
- R7: Read data is combinational from `reg_addr`:
  - offset 0 returns the counter;
  - offset 1 returns the flags in bits 5:0;
  - offset 2 always returns 0;
  - offset 3 returns the routing mask in bits 3:0.
  Unused upper bits read 0.
- R8: The routing mask at offset 3 is read/write, holds bits 3:0, and resets to 0.
- R9: `dest_busy[k]` equals combined busy AND mask bit k, registered. It shows a message change one clock later.
- R10: Synchronous reset drives the counter, flags, mask and `dest_busy` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg | input | 8 | Current decoded flow-control byte |
| perr_pulse | input | 1 | One-cycle parity-error strobe |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data |
| busy_now | output | 1 | Combined busy, combinational |
| dest_busy | output | 4 | Routed busy lanes: 0 trigger path, 1-3 bulk paths |

## Verification
The hardest condition to reach from the ports is counter saturation. It needs 65,535 strobes before the ceiling is hit. The bench therefore drives a continuous run of strobes past the ceiling and checks that the count stops at all ones. The clear-versus-set collisions also need care: the bench writes the clear register in the same cycle as a live source bit or a parity strobe. Around these cases, the bench sweeps all 256 message values for busy and flags, and all 16 routing masks for the lanes.

// File: rtl/busy_monitor.sv
module busy_monitor #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        msg,
  input  logic              perr_pulse,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              busy_now,
  output logic [LANES-1:0]  dest_busy
);
  localparam int NSRC = 6;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] err_cnt;
  logic [NSRC-1:0]  flags;
  logic [LANES-1:0] mask;
  logic [NSRC-1:0]  src;
  logic             clr_cnt, clr_flags;

  assign src       = {msg[6:4], msg[2:0]};
  assign busy_now  = |src;
  assign clr_cnt   = reg_wr && reg_addr == 2'd2 && reg_wdata[0];
  assign clr_flags = reg_wr && reg_addr == 2'd2 && reg_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) err_cnt <= '0;
    else if (clr_cnt) err_cnt <= '0;
    else if (perr_pulse && err_cnt != CNT_MAX) err_cnt <= err_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else if (clr_flags) flags <= '0;
    else flags <= flags | src;
  end

  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else if (reg_wr && reg_addr == 2'd3) mask <= reg_wdata[LANES-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) dest_busy <= '0;
    else dest_busy <= {LANES{busy_now}} & mask;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[CNT_W-1:0] = err_cnt;
      2'd1: reg_rdata[NSRC-1:0]  = flags;
      2'd3: reg_rdata[LANES-1:0] = mask;
      default: reg_rdata = '0;
    endcase
  end

  a_r2_flag_sets: assert property (@(posedge clk) disable iff (rst)
    !clr_flags |=> ((flags & $past(src)) == $past(src)));
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_flags |=> ((flags & $past(flags)) == $past(flags)));
  a_r4_cnt_step: assert property (@(posedge clk) disable iff (rst)
    (!clr_cnt && perr_pulse && err_cnt != CNT_MAX) |=> err_cnt == $past(err_cnt) + 1'b1);
  a_r4_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr_cnt && !perr_pulse) |=> $stable(err_cnt));
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (!clr_cnt && err_cnt == CNT_MAX) |=> err_cnt == CNT_MAX);
  a_r6_cnt_clear: assert property (@(posedge clk) disable iff (rst)
    clr_cnt |=> err_cnt == '0);
  a_r6_flag_clear: assert property (@(posedge clk) disable iff (rst)
    clr_flags |=> flags == '0);
  a_r9_idle_lanes: assert property (@(posedge clk) disable iff (rst)
    !busy_now |=> dest_busy == '0);
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (err_cnt == '0 && flags == '0 && mask == '0 && dest_busy == '0));
endmodule

// File: tb/busy_monitor_test.sv
module busy_monitor_test;
  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  msg = 0;
  logic        perr_pulse = 0;
  logic [1:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        busy_now;
  logic [3:0]  dest_busy;
  int checks = 0, fails = 0;

  busy_monitor uut (.*);

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick();
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [15:0] exp);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  function automatic logic [5:0] srcs(logic [7:0] m);
    return {m[6:4], m[2:0]};
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0; #1;
    // R10 reset state
    rd(2'd0, "R10 cnt", 16'h0);
    rd(2'd1, "R10 flags", 16'h0);
    rd(2'd3, "R10 mask/R8", 16'h0);
    check("R10 dest", dest_busy, 4'h0);

    // R1 R2 R3 R6: sweep every message value
    for (int v = 0; v < 256; v++) begin
      msg = v[7:0]; #1;
      check("R1 busy", busy_now, |srcs(v[7:0]));
      wr(2'd2, 16'h2);
      rd(2'd1, "R6 flag clear wins", 16'h0);
      tick();
      rd(2'd1, "R2 flag set", {10'h0, srcs(v[7:0])});
      msg = 0;
      tick();
      rd(2'd1, "R3 sticky", {10'h0, srcs(v[7:0])});
    end
    wr(2'd2, 16'h2);

    // R7 clear register reads zero
    rd(2'd2, "R7 clear reads 0", 16'h0);

    // R4 counting with gaps
    for (int i = 0; i < 7; i++) begin
      perr_pulse = 1; tick(); perr_pulse = 0; tick();
    end
    rd(2'd0, "R4 count 7", 16'd7);
    tick(); tick();
    rd(2'd0, "R4 holds", 16'd7);

    // R6 clear against simultaneous strobe
    perr_pulse = 1;
    wr(2'd2, 16'h1);
    perr_pulse = 0;
    rd(2'd0, "R6 cnt clear wins", 16'h0);

    // R5 saturation
    perr_pulse = 1;
    for (int i = 0; i < 65540; i++) tick();
    perr_pulse = 0;
    rd(2'd0, "R5 saturate", 16'hFFFF);
    perr_pulse = 1; tick(); perr_pulse = 0;
    rd(2'd0, "R5 no wrap", 16'hFFFF);
    wr(2'd2, 16'h1);
    rd(2'd0, "R6 cnt cleared", 16'h0);

    // R8 R9 routing sweep
    for (int m = 0; m < 16; m++) begin
      wr(2'd3, 16'hFFF0 | m[15:0]);
      rd(2'd3, "R8 mask readback", m[15:0]);
      msg = 8'h88; tick();
      check("R9/R1 parity bits idle", dest_busy, 4'h0);
      msg = 8'h10; #1;
      check("R9 latency", dest_busy, 4'h0);
      tick();
      check("R9 routed", dest_busy, m[3:0]);
      msg = 0; tick();
      check("R9 release", dest_busy, 4'h0);
    end

    // R10 reset mid-run
    msg = 8'h7F; perr_pulse = 1; tick();
    rst = 1; tick(); rst = 0; msg = 0; perr_pulse = 0; #1;
    rd(2'd0, "R10 cnt", 16'h0);
    rd(2'd3, "R10 mask", 16'h0);
    check("R10 dest", dest_busy, 4'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule